// File: doc/BRIEF.md
# Synchronous Burst Pipelined SRAM

A single-port synchronous static RAM of 32-bit words, 64K words in its full configuration (`AddrW` = 16). Address, control and write data are registered on the rising clock edge. A two-bit burst counter produces the low two address bits of a four-word burst. The counter runs in interleaved order (start XOR step) or in linear order (start plus step, modulo four). Either of two address strobes starts a burst, and an advance input steps through it. Writes are made per byte lane. A global-write input stores the whole word at once.

Read data leaves either through an extra output register (pipelined) or straight from the array read register (flow-through). The pad driver is gated asynchronously by an output-enable input. A strap sampled only while reset is held sets the deselect behaviour. In the "one-cycle" mode, deselecting through the secondary chip enables drops the read word still in flight. In the "two-cycle" mode that word is still driven, so back-to-back bursts on two banks can run without a dead cycle. A snooze input blocks all accesses and keeps the array contents.

Top module: `sbsram_top`

## Requirements
- R1: While reset is held and after it is released, `dqDrive` is 0 and no burst is active until an address strobe is accepted.
- R2: A strobe cycle with `allWriteN` low stores all 32 bits of `wrData` at `addrIn`. A later read of that address returns the word. The array holds 2**AddrW words.
- R3: A strobe (`ctrlStrobeN` or `cpuStrobeN` low while selected) loads the address and clears the step k to 0. Each later cycle with `advN` low and no strobe increments k by 1, modulo 4. The upper address bits come from the strobe. The low two bits are start XOR k when `orderSel` is 1, and (start + k) mod 4 when `orderSel` is 0.
- R4: A read issued at clock edge n is driven after edge n+2 when `flowThruN` is 1 (pipelined), and after edge n+1 when `flowThruN` is 0 (flow-through).
- R5: With `allWriteN` high and `byteWrEnN` low, bits 8i+7..8i are written when `laneWrN[i]` is low. The other lanes keep their contents.
- R6: A cycle with `allWriteN` and `byteWrEnN` both high writes nothing. So does a cycle with `byteWrEnN` low and `laneWrN` = 4'b1111. Such a cycle is a read.
- R7: `outEnN` high forces `dqDrive` to 0 at once, without waiting for a clock edge. Lowering it restores the drive at once.
- R8: With `strapIn` low at reset, a strobe accepted at edge n while `bankSel` is 0 or `bankSelN` is 1 ends the burst. The pipelined word due after edge n+1 is dropped, so `dqDrive` is 0 from then on.
- R9: With `strapIn` high at reset, under the same deselect the word due after edge n+1 is still driven, and `dqDrive` is 0 after edge n+2.
- R10: `strapIn` is sampled only while `rstN` is low. Later changes have no effect on the deselect behaviour.
- R11: While `snooze` is 1, no read or write is issued and the burst state is held. The array keeps its contents.
- R12: `advN` low with no active burst issues no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rstN | input | 1 | Active-low reset (asynchronous for pipeline state) |
| addrIn | input | AddrW | Word address |
| chipSelN | input | 1 | Primary chip enable, active low |
| bankSel | input | 1 | Secondary chip enable, active high |
| bankSelN | input | 1 | Secondary chip enable, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| cpuStrobeN | input | 1 | Processor-side address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| allWriteN | input | 1 | Global write of all lanes, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneWrN | input | 4 | Per-lane write strobes, active low |
| wrData | input | 32 | Write data |
| outEnN | input | 1 | Asynchronous output enable, active low |
| orderSel | input | 1 | 1 interleaved burst order, 0 linear |
| flowThruN | input | 1 | 0 flow-through output, 1 pipelined output |
| snooze | input | 1 | Low-power state, active high |
| strapIn | input | 1 | Deselect mode strap: 0 one-cycle, 1 two-cycle |
| dqOut | output | 32 | Read data toward the pads |
| dqDrive | output | 1 | Pad driver enable; 0 means high impedance |

## Verification
The bench builds the block with `AddrW` = 6, a 64-word array. At that size every word can be written with its own arithmetic pattern, and a burst can be started from every address in both orders and both output modes. All 16 byte-lane masks are applied to one word. Both strap values are exercised, including a strap change after reset, so the deselect timings of the two modes can be compared cycle by cycle.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LaneW     = 8;
  localparam int Lanes     = 4;
  localparam int WordW     = Lanes * LaneW;
  localparam int BurstBits = 2;

  // strobes from control to datapath, registered at the input edge
  typedef struct packed {
    logic             rdIssue;
    logic [Lanes-1:0] wrLanes;
    logic             killOut;
  } stb_t;
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int AddrW = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] addrIn,
  input  logic             chipSelN,
  input  logic             bankSel,
  input  logic             bankSelN,
  input  logic             ctrlStrobeN,
  input  logic             cpuStrobeN,
  input  logic             advN,
  input  logic             allWriteN,
  input  logic             byteWrEnN,
  input  logic [Lanes-1:0] laneWrN,
  input  logic             orderSel,
  input  logic             snooze,
  input  logic             strapIn,
  output stb_t             stb,
  output logic [AddrW-1:0] accAddr
);
  logic [AddrW-1:0]     baseAddr;
  logic [BurstBits-1:0] stepCnt;
  logic                 burstOn;
  logic                 twoCycMode;

  logic                 secOff, selOk, anyStrobe;
  logic                 startNow, stepNow, deselNow, issueNow;
  logic [Lanes-1:0]     wrNow;
  logic [BurstBits-1:0] nextCnt, startLow, burstLow;
  logic [AddrW-1:0]     issueAddr;

  always_comb begin
    secOff    = ~bankSel | bankSelN;
    selOk     = ~chipSelN & ~secOff;
    anyStrobe = ~ctrlStrobeN | ~cpuStrobeN;
    startNow  = ~snooze & anyStrobe & selOk;
    deselNow  = ~snooze & anyStrobe & ~selOk;
    stepNow   = ~snooze & ~anyStrobe & burstOn & ~advN;
    issueNow  = startNow | stepNow;
    if (!allWriteN)      wrNow = {Lanes{1'b1}};
    else if (!byteWrEnN) wrNow = ~laneWrN;
    else                 wrNow = '0;
    nextCnt  = startNow ? '0 : stepCnt + BurstBits'(1);
    startLow = startNow ? addrIn[BurstBits-1:0] : baseAddr[BurstBits-1:0];
    burstLow = orderSel ? (startLow ^ nextCnt) : (startLow + nextCnt);
    issueAddr = startNow ? addrIn : {baseAddr[AddrW-1:BurstBits], burstLow};
  end

  // strap is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) twoCycMode <= strapIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      stepCnt  <= '0;
      burstOn  <= 1'b0;
      stb      <= '0;
      accAddr  <= '0;
    end else begin
      if (startNow) begin
        baseAddr <= addrIn;
        stepCnt  <= '0;
        burstOn  <= 1'b1;
      end else if (stepNow) begin
        stepCnt  <= nextCnt;
      end else if (deselNow) begin
        burstOn  <= 1'b0;
      end
      stb.rdIssue <= issueNow & ~|wrNow;
      stb.wrLanes <= issueNow ? wrNow : '0;
      stb.killOut <= deselNow & secOff & ~twoCycMode;
      accAddr     <= issueAddr;
    end
  end
endmodule

// File: rtl/sbsram_dp.sv
module sbsram_dp
  import sbsram_pkg::*;
#(
  parameter int AddrW = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  stb_t             stb,
  input  logic [AddrW-1:0] accAddr,
  input  logic [WordW-1:0] wrData,
  output logic [WordW-1:0] flowData,
  output logic             flowValid,
  output logic [WordW-1:0] pipeData,
  output logic             pipeValid
);
  localparam int Depth = 1 << AddrW;

  logic [WordW-1:0] mem [Depth];
  logic [WordW-1:0] wrDataQ;

  // array write per lane, array read register, output register
  always_ff @(posedge clk) begin
    wrDataQ <= wrData;
    for (int l = 0; l < Lanes; l++) begin
      if (stb.wrLanes[l]) mem[accAddr][l*LaneW +: LaneW] <= wrDataQ[l*LaneW +: LaneW];
    end
    flowData <= mem[accAddr];
    pipeData <= flowData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flowValid <= 1'b0;
      pipeValid <= 1'b0;
    end else begin
      flowValid <= stb.rdIssue;
      pipeValid <= flowValid & ~stb.killOut;
    end
  end
endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
  import sbsram_pkg::*;
#(
  parameter int AddrW = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] addrIn,
  input  logic             chipSelN,
  input  logic             bankSel,
  input  logic             bankSelN,
  input  logic             ctrlStrobeN,
  input  logic             cpuStrobeN,
  input  logic             advN,
  input  logic             allWriteN,
  input  logic             byteWrEnN,
  input  logic [3:0]       laneWrN,
  input  logic [31:0]      wrData,
  input  logic             outEnN,
  input  logic             orderSel,
  input  logic             flowThruN,
  input  logic             snooze,
  input  logic             strapIn,
  output logic [31:0]      dqOut,
  output logic             dqDrive
);
  stb_t             ctrlStb;
  logic [AddrW-1:0] accAddr;
  logic [WordW-1:0] flowData, pipeData;
  logic             flowValid, pipeValid;

  sbsram_ctrl #(.AddrW(AddrW)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .chipSelN(chipSelN),
    .bankSel(bankSel), .bankSelN(bankSelN), .ctrlStrobeN(ctrlStrobeN),
    .cpuStrobeN(cpuStrobeN), .advN(advN), .allWriteN(allWriteN),
    .byteWrEnN(byteWrEnN), .laneWrN(laneWrN), .orderSel(orderSel),
    .snooze(snooze), .strapIn(strapIn), .stb(ctrlStb), .accAddr(accAddr)
  );

  sbsram_dp #(.AddrW(AddrW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .accAddr(accAddr), .wrData(wrData),
    .flowData(flowData), .flowValid(flowValid),
    .pipeData(pipeData), .pipeValid(pipeValid)
  );

  assign dqOut   = flowThruN ? pipeData : flowData;
  assign dqDrive = (flowThruN ? pipeValid : flowValid) & ~outEnN;
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk (
  input logic clk,
  input logic rstN,
  input logic outEnN,
  input logic snooze,
  input logic dqDrive,
  input logic pipeValid,
  input logic rdIssue,
  input logic killOut
);
  always_comb begin
    // R1
    if (!rstN) reset_quiet_chk: assert (!dqDrive);
    // R7
    if (rstN && outEnN) oe_float_chk: assert (!dqDrive);
  end

  // R4
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pipeValid) |-> $past(rdIssue, 2));

  // R8
  one_cyc_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    killOut |=> !pipeValid);

  // R11
  snooze_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(snooze) && $past(snooze, 2) && $past(snooze, 3)) |-> !dqDrive);
endmodule

bind sbsram_top sbsram_chk u_chk (
  .clk(clk), .rstN(rstN), .outEnN(outEnN), .snooze(snooze), .dqDrive(dqDrive),
  .pipeValid(pipeValid), .rdIssue(ctrlStb.rdIssue), .killOut(ctrlStb.killOut)
);

// File: tb/test_sbsram_top.sv
module test_sbsram_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic chipSelN, bankSel, bankSelN, ctrlStrobeN, cpuStrobeN, advN;
  logic allWriteN, byteWrEnN, outEnN;
  logic [3:0] laneWrN;
  logic [31:0] wrData = '0;
  logic orderSel = 1'b1, flowThruN = 1'b1, snooze = 1'b0, strapIn = 1'b0;
  logic [31:0] dqOut;
  logic dqDrive;

  logic [31:0] model [0:WORDS-1];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sbsram_top #(.AddrW(AW)) i_sbsram_top (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .chipSelN(chipSelN),
    .bankSel(bankSel), .bankSelN(bankSelN), .ctrlStrobeN(ctrlStrobeN),
    .cpuStrobeN(cpuStrobeN), .advN(advN), .allWriteN(allWriteN),
    .byteWrEnN(byteWrEnN), .laneWrN(laneWrN), .wrData(wrData), .outEnN(outEnN),
    .orderSel(orderSel), .flowThruN(flowThruN), .snooze(snooze), .strapIn(strapIn),
    .dqOut(dqOut), .dqDrive(dqDrive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below 150000", cycles);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleIn();
    chipSelN = 1'b0; bankSel = 1'b1; bankSelN = 1'b0;
    ctrlStrobeN = 1'b1; cpuStrobeN = 1'b1; advN = 1'b1;
    allWriteN = 1'b1; byteWrEnN = 1'b1; laneWrN = 4'hF; outEnN = 1'b0;
  endtask

  task automatic doReset(input logic strap);
    strapIn = strap;
    rstN = 1'b0;
    idleIn();
    repeat (3) @(negedge clk);
    check(!dqDrive, "R1 drive in reset", {31'b0, dqDrive}, 32'd0);
    rstN = 1'b1;
  endtask

  function automatic int bAddr(input int a, input bit ilv, input int k);
    int lo;
    lo = a & 3;
    return (a & ~3) | (ilv ? (lo ^ k) : ((lo + k) & 3));
  endfunction

  // single strobe write; bench model merges lanes arithmetically
  task automatic writeWord(input int a, input logic [31:0] d, input logic gw,
                           input logic bwe, input logic [3:0] lanesN);
    @(negedge clk);
    idleIn();
    ctrlStrobeN = 1'b0; addrIn = AW'(a); wrData = d;
    allWriteN = gw; byteWrEnN = bwe; laneWrN = lanesN;
    if (!gw) model[a] = d;
    else if (!bwe) begin
      for (int l = 0; l < 4; l++)
        if (!lanesN[l]) model[a][l*8 +: 8] = d[l*8 +: 8];
    end
    @(negedge clk);
    idleIn();
  endtask

  // four-word read burst; checks every output cycle
  task automatic readBurst(input int a, input bit ilv, input bit pipe,
                           input int oeCyc, input string req);
    int lat;
    orderSel = ilv; flowThruN = pipe;
    lat = pipe ? 3 : 2;
    for (int c = 0; c < 9; c++) begin
      int idx;
      @(negedge clk);
      idx = c - lat;
      if (idx >= 0 && idx < 4) begin
        check(dqDrive && dqOut == model[bAddr(a, ilv, idx)], req, dqOut, model[bAddr(a, ilv, idx)]);
      end else if (c == lat - 1) begin
        check(!dqDrive, "R4 not yet driven", {31'b0, dqDrive}, 32'd0);
      end else if (c >= lat + 4) begin
        check(!dqDrive, req, {31'b0, dqDrive}, 32'd0);
      end
      idleIn();
      if (c == 0) begin
        if (a[0]) cpuStrobeN = 1'b0; else ctrlStrobeN = 1'b0;
        addrIn = AW'(a);
      end else if (c < 4) advN = 1'b0;
      if (c == oeCyc) begin
        outEnN = 1'b1;
        #1;
        check(!dqDrive, "R7 output enable off", {31'b0, dqDrive}, 32'd0);
        outEnN = 1'b0;
        #1;
        check(dqDrive, "R7 output enable on", {31'b0, dqDrive}, 32'd1);
      end
    end
  endtask

  // two-word burst followed by a secondary deselect strobe
  task automatic deselTest(input bit twoCyc, input string req);
    orderSel = 1'b1; flowThruN = 1'b1;
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      if (c == 3) check(dqDrive && dqOut == model[8], req, dqOut, model[8]);
      if (c == 4) begin
        if (twoCyc) check(dqDrive && dqOut == model[9], req, dqOut, model[9]);
        else check(!dqDrive, req, {31'b0, dqDrive}, 32'd0);
      end
      if (c == 5) check(!dqDrive, req, {31'b0, dqDrive}, 32'd0);
      idleIn();
      if (c == 0) begin ctrlStrobeN = 1'b0; addrIn = AW'(8); end
      if (c == 1) advN = 1'b0;
      if (c == 2) begin ctrlStrobeN = 1'b0; addrIn = AW'(40); bankSel = (c & 1) == 1; end
    end
  endtask

  initial begin
    idleIn();
    doReset(1'b0);

    // R12: advance with no burst
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(!dqDrive, "R12 advance without burst", {31'b0, dqDrive}, 32'd0);
      advN = 1'b0;
    end
    idleIn();

    // R2: fill every word with a full-word write
    for (int a = 0; a < WORDS; a++)
      writeWord(a, (32'(a) * 32'h0103_0507) ^ 32'h5A3C_0F00, 1'b0, 1'b1, 4'hF);

    // R2 linear and R3 interleaved, pipelined, every start address
    for (int a = 0; a < WORDS; a++) readBurst(a, 1'b0, 1'b1, -1, "R2 R3 linear pipelined");
    for (int a = 0; a < WORDS; a++) readBurst(a, 1'b1, 1'b1, -1, "R3 interleaved pipelined");
    // R4: flow-through, both orders
    for (int a = 0; a < WORDS; a++) readBurst(a, a[1], 1'b0, -1, "R4 flow-through");

    // R5: all lane masks on one word
    for (int m = 0; m < 16; m++) begin
      writeWord(20, 32'h1122_3344, 1'b0, 1'b1, 4'hF);
      writeWord(20, 32'hAABB_CCDD ^ 32'(m), 1'b1, 1'b0, ~4'(m));
      readBurst(20, 1'b1, 1'b1, -1, "R5 byte lanes");
    end

    // R6: write controls idle, then enable with no lane
    writeWord(7, 32'hFFFF_0000, 1'b1, 1'b1, 4'h0);
    readBurst(7, 1'b0, 1'b1, -1, "R6 no write without enables");
    writeWord(7, 32'h0000_FFFF, 1'b1, 1'b0, 4'hF);
    readBurst(7, 1'b0, 1'b1, -1, "R6 no write without lanes");

    // R7: asynchronous output enable during a burst
    readBurst(12, 1'b1, 1'b1, 4, "R7 burst data");

    // R11: snooze blocks access, retains contents
    snooze = 1'b1;
    @(negedge clk);
    ctrlStrobeN = 1'b0; addrIn = AW'(3); wrData = 32'hDEAD_BEEF; allWriteN = 1'b0;
    @(negedge clk);
    idleIn(); ctrlStrobeN = 1'b0; addrIn = AW'(3);
    @(negedge clk);
    idleIn(); advN = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(!dqDrive, "R11 snooze no read", {31'b0, dqDrive}, 32'd0);
    end
    idleIn();
    snooze = 1'b0;
    readBurst(3, 1'b0, 1'b1, -1, "R11 contents retained");

    // R8: one-cycle deselect mode (strap low)
    deselTest(1'b0, "R8 one-cycle deselect");

    // R9: two-cycle deselect mode (strap high)
    doReset(1'b1);
    deselTest(1'b1, "R9 two-cycle deselect");

    // R10: strap change after reset is ignored
    strapIn = 1'b0;
    repeat (2) @(negedge clk);
    deselTest(1'b1, "R10 strap fixed after reset");
    doReset(1'b0);
    strapIn = 1'b1;
    repeat (2) @(negedge clk);
    deselTest(1'b0, "R10 strap fixed after reset");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule